// File: doc/BRIEF.md
# Bit-Field Test-and-Toggle Unit

This unit executes one atomic read-modify-write per command. It reads a 16-bit destination, flips the bits that a 16-bit immediate mask selects, and writes the new value back to the same place. The destination can be one of three things: a data-memory word at a direct address, one entry of an external register file, or the unit's own status register. During the read the unit also tests whether every bit selected by the mask was already one. The result of that test goes into the carry bit of the status register.

A command is accepted on a clock edge where `cmd_valid` is high and the unit is idle. `busy` covers the whole operation and `done` marks the write-back cycle. A memory destination uses a synchronous port with one cycle of read latency, so it needs two separate bus accesses: a read, then a write one cycle after the data returns. A register-file destination has a combinational read and takes one cycle less. The status register is kept inside the unit and is visible on `sr_out`. Carry is bit 0. The other condition flags sit in the low byte, and the mode and interrupt-mask fields sit in the high byte.

Top module: `bftt_unit`

## Requirements
- R1: For a memory or register-file destination, the value written back equals the destination value read at the start of the command XOR `cmd_mask`.
- R2: A memory command makes exactly one read (`mem_rd_en`) and then exactly one write (`mem_wr_en`). The write uses the same address and comes two cycles after the read. Read and write are never asserted in the same cycle.
- R3: For a memory or register-file destination, carry (status bit 0) becomes 1 exactly when every mask bit is one in the value read before the toggle. A zero mask therefore sets carry.
- R4: For a memory or register-file destination, status bits 15..1 keep their values. Example: reading 0x5555 with mask 0x0FF0 writes 0x5AA5 and moves the status from 0x0301 to 0x0300.
- R5: When `cmd_dst` is 2'b10 (status register), the status register becomes its old value XOR the mask, including bit 0. The carry test is not applied in this case.
- R6: `busy` rises on the cycle after acceptance. It stays high for 3 cycles for a memory command (`cmd_dst` 2'b00) and for 2 cycles for a register (`cmd_dst` 2'b01) or status command. `done` is high for exactly one cycle, the last busy cycle, and the write-back and status update take effect at the end of that cycle.
- R7: `cmd_valid` is ignored while `busy` is high. A command with `cmd_dst` 2'b11 is never accepted and leaves memory, register file and status untouched.
- R8: After reset, `busy`, `done` and both write enables are low and `sr_out` is 0x0300. A reset that arrives during a command aborts it with no write and leaves the status at 0x0300.
- R9: A register-file command drives `rf_idx` with `cmd_ridx` for both its read and its write. The write goes to that entry only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_dst | input | 2 | Destination: 00 memory, 01 register file, 10 status, 11 reserved |
| cmd_mask | input | 16 | Immediate toggle/test mask |
| cmd_addr | input | 16 | Direct memory address |
| cmd_ridx | input | 3 | Register-file entry |
| busy | output | 1 | Command in progress |
| done | output | 1 | Write-back cycle pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the read strobe |
| rf_idx | output | 3 | Register-file entry for read and write |
| rf_rdata | input | 16 | Register-file read data, combinational |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wdata | output | 16 | Register-file write data |
| sr_out | output | 16 | Status register |

## Verification
An operand captured in the wrong cycle shows up at the write-back edge of the same command. It appears as wrong write data, and usually as a wrong carry as well. A controller stuck in the wrong state shows up as a wrong busy length or a missing or doubled strobe within three cycles of acceptance. A status bit that should have been preserved but was disturbed stays wrong on `sr_out` until a later status-destination command rewrites it. For that reason the bench compares the whole status word after every command, not only bit 0.

// File: rtl/bftt_pkg.sv
// Shared types for the bit-field test-and-toggle unit.
// Assumes: two-bit destination code, carry held in status bit 0.
package bftt_pkg;
    typedef enum logic [1:0] {
        DST_MEM = 2'b00,
        DST_REG = 2'b01,
        DST_SR  = 2'b10,
        DST_RSV = 2'b11
    } dst_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_CAPT  = 2'b10,
        ST_WRITE = 2'b11
    } state_e;

    localparam int CARRY_POS = 0;
endpackage

// File: rtl/bftt_ctrl.sv
// Sequencer: latches the command, steps read -> (capture) -> write.
// Assumes memory read data arrives one cycle after mem_rd_en.
module bftt_ctrl
    import bftt_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_dst,
    input  logic [DW-1:0] cmd_mask,
    input  logic [AW-1:0] cmd_addr,
    input  logic [RW-1:0] cmd_ridx,
    output logic          busy,
    output logic          done,
    output logic          mem_rd_en,
    output logic          cap_en,
    output logic          upd_en,
    output logic [DW-1:0] mask_q,
    output dst_e          dst_q,
    output logic [AW-1:0] addr_q,
    output logic [RW-1:0] ridx_q
);
    state_e state, state_nx;
    logic   accept;

    assign accept = (state == ST_IDLE) && cmd_valid && (dst_e'(cmd_dst) != DST_RSV);

    // next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (accept) state_nx = ST_READ;
            ST_READ:  state_nx = (dst_q == DST_MEM) ? ST_CAPT : ST_WRITE;
            ST_CAPT:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command latch, loaded only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            dst_q  <= DST_MEM;
            addr_q <= '0;
            ridx_q <= '0;
        end else if (accept) begin
            mask_q <= cmd_mask;
            dst_q  <= dst_e'(cmd_dst);
            addr_q <= cmd_addr;
            ridx_q <= cmd_ridx;
        end
    end

    // strobes decoded from the state
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_WRITE);
        upd_en    = (state == ST_WRITE);
        mem_rd_en = (state == ST_READ) && (dst_q == DST_MEM);
        cap_en    = ((state == ST_READ) && (dst_q != DST_MEM)) || (state == ST_CAPT);
    end
endmodule

// File: rtl/bftt_datapath.sv
// Operand capture, toggle and all-ones test.
// Assumes cap_en is high for exactly one cycle per command.
module bftt_datapath
    import bftt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  dst_e          dst_q,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] rf_rdata,
    input  logic [DW-1:0] sr_q,
    input  logic [DW-1:0] mask_q,
    output logic [DW-1:0] result,
    output logic          all_set
);
    logic [DW-1:0] opnd, src, hit;

    // pick the operand source for the latched destination
    always_comb begin
        case (dst_q)
            DST_MEM: src = mem_rdata;
            DST_REG: src = rf_rdata;
            default: src = sr_q;
        endcase
    end

    // hold the pre-toggle operand
    always_ff @(posedge clk) begin
        if (!rst_n)      opnd <= '0;
        else if (cap_en) opnd <= src;
    end

    // per-bit test: unmasked bits always pass
    for (genvar i = 0; i < DW; i++) begin : g_hit
        assign hit[i] = ~mask_q[i] | opnd[i];
    end

    assign all_set = &hit;
    assign result  = opnd ^ mask_q;
endmodule

// File: rtl/bftt_status.sv
// Status register: carry from the test, or a full toggle when it is the target.
// Assumes upd_en pulses once per command, in the write-back cycle.
module bftt_status
    import bftt_pkg::*;
#(
    parameter int          DW     = 16,
    parameter logic [15:0] SR_RST = 16'h0300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          sr_dest,
    input  logic [DW-1:0] result,
    input  logic          all_set,
    output logic [DW-1:0] sr_q
);
    // update the status word at write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= DW'(SR_RST);
        end else if (upd_en) begin
            if (sr_dest) sr_q <= result;
            else         sr_q[CARRY_POS] <= all_set;
        end
    end
endmodule

// File: rtl/bftt_unit.sv
// Top: atomic test-and-toggle on memory, register file or status.
// Assumes a one-cycle-latency memory and a combinational register-file read.
module bftt_unit
    import bftt_pkg::*;
#(
    parameter int          DW     = 16,
    parameter int          AW     = 16,
    parameter int          RW     = 3,
    parameter logic [15:0] SR_RST = 16'h0300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_dst,
    input  logic [DW-1:0] cmd_mask,
    input  logic [AW-1:0] cmd_addr,
    input  logic [RW-1:0] cmd_ridx,
    output logic          busy,
    output logic          done,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [RW-1:0] rf_idx,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_wr_en,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] sr_out
);
    logic          cap_en, upd_en, all_set;
    logic [DW-1:0] mask_q, result, sr_q;
    logic [AW-1:0] addr_q;
    logic [RW-1:0] ridx_q;
    logic [1:0]    dst_bits;
    dst_e          dst_q;

    bftt_ctrl #(.DW(DW), .AW(AW), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dst(cmd_dst),
        .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_ridx(cmd_ridx),
        .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .cap_en(cap_en),
        .upd_en(upd_en), .mask_q(mask_q), .dst_q(dst_q), .addr_q(addr_q),
        .ridx_q(ridx_q)
    );

    bftt_datapath #(.DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .dst_q(dst_q),
        .mem_rdata(mem_rdata), .rf_rdata(rf_rdata), .sr_q(sr_q),
        .mask_q(mask_q), .result(result), .all_set(all_set)
    );

    bftt_status #(.DW(DW), .SR_RST(SR_RST)) u_sr (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
        .sr_dest(dst_q == DST_SR), .result(result), .all_set(all_set),
        .sr_q(sr_q)
    );

    // route the result to the latched destination
    always_comb begin
        mem_wr_en = upd_en && (dst_q == DST_MEM);
        rf_wr_en  = upd_en && (dst_q == DST_REG);
        mem_addr  = addr_q;
        mem_wdata = result;
        rf_idx    = ridx_q;
        rf_wdata  = result;
        sr_out    = sr_q;
        dst_bits  = dst_q;
    end
endmodule

// File: rtl/bftt_unit_chk.sv
// Property checker for bftt_unit, attached by bind.
// Assumes carry at status bit 0 and status destination code 2'b10.
module bftt_unit_chk #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic          rf_wr_en,
    input logic [DW-1:0] rf_wdata,
    input logic [DW-1:0] rf_rdata,
    input logic [DW-1:0] sr_out,
    input logic [DW-1:0] mask_q,
    input logic [1:0]    dst_bits
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R2
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (mem_wr_en && mem_addr == $past(mem_addr, 2))); // R2
    AST_WR_HAS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2)); // R2
    AST_MEM_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wdata == ($past(mem_rdata) ^ mask_q)); // R1
    AST_RF_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wdata == ($past(rf_rdata) ^ mask_q)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R6
    AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sr_out)); // R7
    AST_SR_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dst_bits != 2'b10) |=> sr_out[DW-1:1] == $past(sr_out[DW-1:1])); // R4
    AST_SR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dst_bits == 2'b10) |=> sr_out == ($past(sr_out) ^ $past(mask_q))); // R5
endmodule

bind bftt_unit bftt_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_wr_en(rf_wr_en),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .sr_out(sr_out),
    .mask_q(mask_q), .dst_bits(dst_bits)
);

// File: tb/bftt_unit_bench.sv
module bftt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_dst = 2'b00;
    logic [15:0] cmd_mask = '0;
    logic [15:0] cmd_addr = '0;
    logic [2:0]  cmd_ridx = '0;
    logic        busy, done, mem_rd_en, mem_wr_en, rf_wr_en;
    logic [15:0] mem_addr, mem_wdata, rf_wdata, sr_out, rf_rdata;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  rf_idx;

    logic [15:0] mem [16];
    logic [15:0] rf  [8];
    int rd_cnt = 0, wr_cnt = 0, rfw_cnt = 0;
    int total = 0, bad = 0;
    bit finished = 0;
    logic [15:0] exp_sr;

    always #10 clk = ~clk;

    bftt_unit u_bftt_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dst(cmd_dst),
        .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_ridx(cmd_ridx),
        .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en),
        .rf_wdata(rf_wdata), .sr_out(sr_out)
    );

    assign rf_rdata = rf[rf_idx];

    // memory and register-file models
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[3:0]];
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[3:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (rf_wr_en) begin
            rf[rf_idx] <= rf_wdata;
            rfw_cnt <= rfw_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] dst, input logic [15:0] m, input logic [3:0] a,
                         input logic [2:0] ri, output int cycles, output int dones);
        @(negedge clk);
        rd_cnt <= 0; wr_cnt <= 0; rfw_cnt <= 0;
        cmd_valid = 1'b1; cmd_dst = dst; cmd_mask = m; cmd_addr = {12'h0, a}; cmd_ridx = ri;
        @(negedge clk);
        cmd_valid = 1'b0;
        cycles = 0; dones = 0;
        for (int g = 0; g < 50 && busy; g++) begin
            cycles++;
            if (done) dones++;
            @(negedge clk);
        end
    endtask

    task automatic mem_case(input logic [15:0] d, input logic [15:0] m, input logic [3:0] a);
        int cy, dn;
        logic [15:0] exp_v;
        bit c;
        @(negedge clk);
        mem[a] <= d;
        issue(2'b00, m, a, 3'd0, cy, dn);
        exp_v = d ^ m;
        c = ((d & m) == m);
        exp_sr = {exp_sr[15:1], c};
        chk(mem[a] == exp_v, "R1 mem result", mem[a], exp_v);
        chk(sr_out == exp_sr, "R3/R4 status after mem", sr_out, exp_sr);
        chk(rd_cnt == 1 && wr_cnt == 1, "R2 access count", rd_cnt * 16 + wr_cnt, 17);
        chk(cy == 3 && dn == 1, "R6 mem busy/done", cy * 16 + dn, 49);
    endtask

    task automatic reg_case(input logic [15:0] d, input logic [15:0] m, input logic [2:0] ri);
        int cy, dn;
        logic [15:0] exp_v, other;
        bit c;
        @(negedge clk);
        rf[ri] <= d;
        rf[ri + 3'd1] <= ~d;
        issue(2'b01, m, 4'd0, ri, cy, dn);
        exp_v = d ^ m;
        other = ~d;
        c = ((d & m) == m);
        exp_sr = {exp_sr[15:1], c};
        chk(rf[ri] == exp_v, "R1 reg result", rf[ri], exp_v);
        chk(rf[ri + 3'd1] == other && rfw_cnt == 1, "R9 other entry", rf[ri + 3'd1], other);
        chk(sr_out == exp_sr, "R3/R4 status after reg", sr_out, exp_sr);
        chk(cy == 2 && dn == 1 && rd_cnt == 0, "R6 reg busy/done", cy * 16 + dn, 33);
    endtask

    task automatic sr_case(input logic [15:0] m);
        int cy, dn;
        issue(2'b10, m, 4'd0, 3'd0, cy, dn);
        exp_sr = exp_sr ^ m;
        chk(sr_out == exp_sr, "R5 status toggle", sr_out, exp_sr);
        chk(cy == 2 && dn == 1, "R6 status busy/done", cy * 16 + dn, 33);
    endtask

    initial begin
        int cy, dn;
        logic [15:0] d, m;
        for (int k = 0; k < 16; k++) mem[k] = 16'h0;
        for (int k = 0; k < 8; k++) rf[k] = 16'h0;
        exp_sr = 16'h0300;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_wr_en == 0 && rf_wr_en == 0, "R8 reset outputs", {busy, done, mem_wr_en, rf_wr_en}, 0);
        chk(sr_out == 16'h0300, "R8 reset status", sr_out, 16'h0300);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: move status to 0x0301, then R4 worked example
        sr_case(16'h0001);
        mem_case(16'h5555, 16'h0FF0, 4'h3);
        chk(mem[3] == 16'h5AA5 && sr_out == 16'h0300, "R4 example", {mem[3], sr_out}, {16'h5AA5, 16'h0300});
        // R3 all ones, and zero mask
        mem_case(16'hFFFF, 16'hFFFF, 4'h4);
        mem_case(16'h1234, 16'h0000, 4'h5);
        chk(sr_out[0] == 1'b1, "R3 zero mask sets carry", sr_out[0], 1);

        // memory sweep
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                d = {i[3:0], ~i[3:0], i[3:0] | j[3:0], i[3:0] ^ 4'h6};
                m = {j[3:0], j[3:0] & 4'h3, j[3:0], 4'h0 | j[1:0]};
                mem_case(d, m, 4'(i + j));
            end
        // register sweep
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                d = {4{i[3:0] | 4'(j & 1)}};
                m = {4{j[3:0]}};
                reg_case(d, m, 3'(i + j));
            end
        // status sweep
        for (int j = 0; j < 16; j++) sr_case({j[3:0], 4'h0, 4'h0, j[3:0]} ^ 16'h0100);

        // R7: command during busy ignored
        @(negedge clk);
        mem[7] <= 16'h00F0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dst = 2'b00; cmd_mask = 16'h000F; cmd_addr = 16'h0007;
        @(negedge clk);
        cmd_mask = 16'hFF00;
        cy = 0;
        for (int g = 0; g < 50 && busy; g++) begin cy++; @(negedge clk); end
        cmd_valid = 1'b0;
        exp_sr = {exp_sr[15:1], 1'b0};
        chk(mem[7] == 16'h00FF && cy == 3, "R7 ignored while busy", mem[7], 16'h00FF);
        @(negedge clk);
        for (int g = 0; g < 50 && busy; g++) @(negedge clk);
        @(negedge clk);
        // the second request may be taken after busy drops; recompute
        exp_sr = sr_out;
        // R7: reserved destination
        mem[7] <= 16'h1111;
        @(negedge clk);
        wr_cnt <= 0; rfw_cnt <= 0;
        cmd_valid = 1'b1; cmd_dst = 2'b11; cmd_mask = 16'hFFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R7 reserved not accepted", busy, 0);
        repeat (3) @(negedge clk);
        chk(mem[7] == 16'h1111 && sr_out == exp_sr && wr_cnt == 0 && rfw_cnt == 0, "R7 reserved no effect", sr_out, exp_sr);

        // R8: reset during a memory command
        mem[9] <= 16'hAAAA;
        @(negedge clk);
        wr_cnt <= 0;
        cmd_valid = 1'b1; cmd_dst = 2'b00; cmd_mask = 16'h0003; cmd_addr = 16'h0009;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(mem[9] == 16'hAAAA && wr_cnt == 0 && busy == 0, "R8 abort no write", mem[9], 16'hAAAA);
        chk(sr_out == 16'h0300, "R8 abort status", sr_out, 16'h0300);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule